// File: doc/BRIEF.md
# Reloadable Down-Counting Timer with Register Access

This peripheral counts down from a value that software writes into a pair of load words. When the count expires it raises an interrupt. It can run in one of two ways: it can stop after a single expiry, or it can reload itself and keep running. The counter is either 32 bits wide, where only the low load word matters, or 64 bits wide, where both load words form the start value.

Software reaches the block through a plain 32-bit register port. The port has a write strobe, a read strobe, a three-bit word address and write data. Read data comes back registered. The port gives access to the following:

- The start value.
- The live count.
- The mode and enable settings.
- An interrupt word holding an enable, a raw flag, a masked flag and a write-one clear.
- A shadow view of the count for coherent 64-bit sampling.

Loading all ones and running in periodic 64-bit mode gives a free-running source: the inverted shadow reading then grows with elapsed time.

Top module: `cdtmr_top`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `rdata` is zero.
- R2: Word addresses are fixed: 0 load low, 1 load high, 2 count low, 3 count high, 4 control, 5 interrupt, 6 shadow low, 7 shadow high. In the control word, bit 0 selects periodic running, bit 1 is the run enable and bit 16 selects the 64-bit width. All other control bits read as zero. The load words read back what was written.
- R3: A control write that takes the run enable from 0 to 1 copies the load value into the counter on that edge. After that the counter drops by one on every clock while it is running.
- R4: Writing the run enable to 0 freezes the count. The frozen count does not change until the block is re-armed.
- R5: The count expires when a running counter steps from 1 or sits at 0. The raw flag is set on that edge whatever the interrupt enable is. Arming with a start value N sets the raw flag exactly N clocks after the arming edge.
- R6: In periodic mode, expiry loads the start value again and counting continues, so the raw flag recurs every N clocks.
- R7: In one-shot mode, expiry leaves the counter at 0 and halted. It does not expire again until it is re-armed.
- R8: In 64-bit mode the count spans both load words and borrows across the halves. In 32-bit mode the high load word is ignored and the high count half reads 0.
- R9: In the interrupt word, bit 0 is the enable, bit 1 is the raw flag and bit 2 is the raw flag ANDed with the enable. `irq` follows bit 2.
- R10: Writing the interrupt word with bit 3 set clears the raw flag on that edge. Bit 3 always reads 0. A write with bit 3 clear leaves the raw flag unchanged.
- R11: When an expiry and a clear fall on the same edge, the raw flag stays set.
- R12: Reading shadow low returns the low count half and captures the high half on the same edge. A later read of shadow high returns that captured half, even if the live count has changed since.
- R13: A read strobe sampled on an edge loads `rdata` on that edge with the register value held just before it. `rdata` holds when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, masked status |

## Verification
A read strobe sampled on edge k returns the state that edge k-1 left behind, so every expected count in the bench is the start value minus the clocks between the arming edge and the edge before the read. Raw status and `irq` rise on the edge that is N clocks after arming. The bench therefore checks `irq` at the falling edge just before and just after that edge. A clear, or a clear that collides with an expiry, is checked by the interrupt-word read on the following edge. The driver issues strobes on consecutive falling edges and queues each expected word. The monitor takes each result 5 ns after the sampling edge, so no check depends on the order of processes at an edge.

// File: rtl/cdtmr_pkg.sv
package cdtmr_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_LOAD_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LOAD_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_INTR    = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_SHD_LO  = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_SHD_HI  = 3'd7;

  // control word bit positions
  localparam int unsigned CTL_PER_BIT  = 0;
  localparam int unsigned CTL_RUN_BIT  = 1;
  localparam int unsigned CTL_WIDE_BIT = 16;

  // interrupt word bit positions
  localparam int unsigned INT_EN_BIT  = 0;
  localparam int unsigned INT_RAW_BIT = 1;
  localparam int unsigned INT_MSK_BIT = 2;
  localparam int unsigned INT_CLR_BIT = 3;

  typedef struct packed {
    logic wide;
    logic run;
    logic periodic;
  } ctl_t;

endpackage

// File: rtl/cdtmr_rst_sync.sv
module cdtmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cdtmr_regs.sv
module cdtmr_regs
  import cdtmr_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] load_q,
  output ctl_t                ctl_q,
  output logic                ie_q,
  output logic                arm,
  output logic                arm_wide,
  output logic                clr_req
);

  localparam int unsigned CW = 2 * HALF_W;

  logic          wr_lo, wr_hi, wr_ctl, wr_int, load_we;
  logic [CW-1:0] load_d;
  ctl_t          ctl_d;
  logic          ie_d;

  always_comb begin
    wr_lo   = wr_en && (addr == ADR_LOAD_LO);
    wr_hi   = wr_en && (addr == ADR_LOAD_HI);
    wr_ctl  = wr_en && (addr == ADR_CTRL);
    wr_int  = wr_en && (addr == ADR_INTR);
    load_we = wr_lo || wr_hi;

    load_d = load_q;
    if (wr_lo) load_d[HALF_W-1:0]  = wdata;
    if (wr_hi) load_d[CW-1:HALF_W] = wdata;

    ctl_d.periodic = wdata[CTL_PER_BIT];
    ctl_d.run      = wdata[CTL_RUN_BIT];
    ctl_d.wide     = wdata[CTL_WIDE_BIT];

    ie_d = wdata[INT_EN_BIT];

    // arming: run enable goes from 0 to 1 through a control write
    arm      = wr_ctl && wdata[CTL_RUN_BIT] && !ctl_q.run;
    arm_wide = wdata[CTL_WIDE_BIT];
    clr_req  = wr_int && wdata[INT_CLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ctl_q  <= '0;
      ie_q   <= 1'b0;
    end else begin
      if (load_we) load_q <= load_d;
      if (wr_ctl)  ctl_q  <= ctl_d;
      if (wr_int)  ie_q   <= ie_d;
    end
  end

  AST_CTL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == ADR_CTRL)) |=> $stable(ctl_q)) else $error("control changed without write"); // R2

  AST_LOAD_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr <= ADR_LOAD_HI)) |=> $stable(load_q)) else $error("load changed without write"); // R2

endmodule

// File: rtl/cdtmr_counter.sv
module cdtmr_counter
  import cdtmr_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic                arm_wide,
  input  logic [2*HALF_W-1:0] load,
  input  ctl_t                ctl,
  output logic [2*HALF_W-1:0] cnt_q,
  output logic                expire
);

  localparam int unsigned   CW      = 2 * HALF_W;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic          halt_q, halt_d;
  logic [CW-1:0] cnt_d, eff, narrow_load, reload;
  logic          active, at_end, cnt_en;

  always_comb begin
    narrow_load = {{HALF_W{1'b0}}, load[HALF_W-1:0]};
    eff         = ctl.wide ? cnt_q : {{HALF_W{1'b0}}, cnt_q[HALF_W-1:0]};
    reload      = ctl.wide ? load : narrow_load;
    active      = ctl.run && !halt_q;
    at_end      = (eff == CNT_ONE) || (eff == '0);
    expire      = active && at_end;

    cnt_d  = cnt_q;
    halt_d = halt_q;
    cnt_en = 1'b0;
    if (arm) begin
      cnt_en = 1'b1;
      cnt_d  = arm_wide ? load : narrow_load;
      halt_d = 1'b0;
    end else if (active) begin
      cnt_en = 1'b1;
      if (at_end) begin
        if (ctl.periodic) begin
          cnt_d = reload;
        end else begin
          cnt_d  = '0;
          halt_d = 1'b1;
        end
      end else begin
        cnt_d = eff - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      halt_q <= halt_d;
    end
  end

  AST_ARM_LOADS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && arm_wide) |=> (cnt_q == $past(load))) else $error("arm did not load"); // R3

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !arm) |=> $stable(cnt_q)) else $error("count moved while stopped"); // R4

  AST_ONESHOT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && halt_q && !arm) |=> ($stable(cnt_q) && !expire)) else $error("one-shot restarted"); // R7

  AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ctl.wide) |=> (cnt_q[CW-1:HALF_W] == '0)) else $error("high half nonzero in 32-bit mode"); // R8

endmodule

// File: rtl/cdtmr_irq.sv
module cdtmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  input  logic ie,
  output logic raw_q,
  output logic irq
);

  logic raw_d;

  always_comb begin
    raw_d = raw_q;
    if (clr_req) raw_d = 1'b0;
    if (expire)  raw_d = 1'b1;   // expiry beats a clear on the same edge
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw_d;
  end

  assign irq = raw_q & ie;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q) else $error("expiry lost"); // R11

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !raw_q) else $error("clear ignored"); // R10

  AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !expire) |=> $stable(raw_q)) else $error("raw flag moved"); // R10

endmodule

// File: rtl/cdtmr_rdmux.sv
module cdtmr_rdmux
  import cdtmr_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*HALF_W-1:0] load,
  input  logic [2*HALF_W-1:0] cnt,
  input  ctl_t                ctl,
  input  logic                ie,
  input  logic                raw,
  output logic [HALF_W-1:0]   rdata_q
);

  localparam int unsigned CW = 2 * HALF_W;

  logic [HALF_W-1:0] shd_hi_q, rd_d, ctl_word, int_word;
  logic              shd_we;

  always_comb begin
    ctl_word               = '0;
    ctl_word[CTL_PER_BIT]  = ctl.periodic;
    ctl_word[CTL_RUN_BIT]  = ctl.run;
    ctl_word[CTL_WIDE_BIT] = ctl.wide;

    int_word              = '0;
    int_word[INT_EN_BIT]  = ie;
    int_word[INT_RAW_BIT] = raw;
    int_word[INT_MSK_BIT] = raw & ie;

    shd_we = rd_en && (addr == ADR_SHD_LO);

    case (addr)
      ADR_LOAD_LO: rd_d = load[HALF_W-1:0];
      ADR_LOAD_HI: rd_d = load[CW-1:HALF_W];
      ADR_CNT_LO:  rd_d = cnt[HALF_W-1:0];
      ADR_CNT_HI:  rd_d = cnt[CW-1:HALF_W];
      ADR_CTRL:    rd_d = ctl_word;
      ADR_INTR:    rd_d = int_word;
      ADR_SHD_LO:  rd_d = cnt[HALF_W-1:0];
      default:     rd_d = shd_hi_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      shd_hi_q <= '0;
    end else begin
      if (rd_en)  rdata_q  <= rd_d;
      if (shd_we) shd_hi_q <= cnt[CW-1:HALF_W];
    end
  end

  AST_SHADOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !shd_we |=> $stable(shd_hi_q)) else $error("shadow half changed"); // R12

  AST_RDATA_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q)) else $error("rdata changed without read"); // R13

endmodule

// File: rtl/cdtmr_top.sv
module cdtmr_top
  import cdtmr_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] rdata,
  output logic              irq
);

  localparam int unsigned CW = 2 * HALF_W;

  logic          rst_sync_n;
  logic [CW-1:0] load_q, cnt_q;
  ctl_t          ctl_q;
  logic          ie_q, arm, arm_wide, clr_req, expire, raw_q;

  cdtmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cdtmr_regs #(.HALF_W(HALF_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .load_q   (load_q),
    .ctl_q    (ctl_q),
    .ie_q     (ie_q),
    .arm      (arm),
    .arm_wide (arm_wide),
    .clr_req  (clr_req)
  );

  cdtmr_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .arm      (arm),
    .arm_wide (arm_wide),
    .load     (load_q),
    .ctl      (ctl_q),
    .cnt_q    (cnt_q),
    .expire   (expire)
  );

  cdtmr_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .expire  (expire),
    .clr_req (clr_req),
    .ie      (ie_q),
    .raw_q   (raw_q),
    .irq     (irq)
  );

  cdtmr_rdmux #(.HALF_W(HALF_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .load    (load_q),
    .cnt     (cnt_q),
    .ctl     (ctl_q),
    .ie      (ie_q),
    .raw     (raw_q),
    .rdata_q (rdata)
  );

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> ie_q) else $error("irq without enable"); // R9

endmodule

// File: tb/cdtmr_top_tb_top.sv
`timescale 1ns/1ps
module cdtmr_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;   // 50 MHz

  cdtmr_top dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  // driver tasks: called at a falling edge, one clock each
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.data = e; it.tag = tag;
    expq.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  // monitor: result of a strobe sampled at a rising edge, taken 5 ns later
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en === 1'b1) begin
        #5;
        n_cmp++;
        if (expq.size() == 0) begin
          n_bad++;
          $display("FAIL R13 unexpected read actual=%h expected=none", rdata);
        end else begin
          exp_t it;
          it = expq.pop_front();
          if (rdata !== it.data) begin
            n_bad++;
            $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata, it.data);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    chk_irq(1'b0, "R1");
    for (int i = 0; i < 8; i++) rd(3'(i), 32'h0, "R1");

    // R2: register map, control bit masking, load read-back
    wr(3'd0, 32'h1234_5678);
    wr(3'd1, 32'hA5A5_0001);
    wr(3'd4, 32'hFFFF_FFFC);
    rd(3'd0, 32'h1234_5678, "R2");
    rd(3'd1, 32'hA5A5_0001, "R2");
    rd(3'd4, 32'h0001_0000, "R2");
    wr(3'd4, 32'h0);

    // R3/R5/R7/R8: 32-bit one-shot, start 5, high word ignored
    wr(3'd0, 32'd5);
    wr(3'd1, 32'd7);
    wr(3'd4, 32'h2);                 // edge E: count = 5
    rd(3'd2, 32'd5, "R3");           // E+1 sees 5
    rd(3'd3, 32'd0, "R8");           // E+2 high half 0
    rd(3'd2, 32'd3, "R3");           // E+3
    rd(3'd2, 32'd2, "R3");           // E+4
    rd(3'd5, 32'h0, "R5");           // E+5: not yet expired before this edge
    rd(3'd5, 32'h2, "R5");           // E+6: raw set, enable off
    chk_irq(1'b0, "R9");
    rd(3'd2, 32'd0, "R7");
    idle(3);
    rd(3'd2, 32'd0, "R7");
    wr(3'd5, 32'h8);                 // clear
    rd(3'd5, 32'h0, "R10");          // also bit 3 reads 0
    idle(2);
    rd(3'd5, 32'h0, "R7");           // no re-expiry
    wr(3'd4, 32'h0);

    // R6/R9/R10/R11/R4: periodic, start 3, interrupt enabled
    wr(3'd5, 32'h1);
    wr(3'd0, 32'd3);
    wr(3'd4, 32'h3);                 // E
    idle(2);                         // E+1, E+2
    chk_irq(1'b0, "R5");
    idle(1);                         // E+3 expiry
    chk_irq(1'b1, "R9");
    rd(3'd2, 32'd3, "R6");           // E+4 reloaded
    rd(3'd2, 32'd2, "R6");           // E+5
    rd(3'd5, 32'h7, "R9");           // E+6 (expiry again on this edge)
    wr(3'd5, 32'h9);                 // E+7 clear, enable kept
    rd(3'd5, 32'h1, "R10");          // E+8
    chk_irq(1'b0, "R10");
    wr(3'd5, 32'h9);                 // E+9 clear on expiry edge
    rd(3'd5, 32'h7, "R11");          // E+10
    chk_irq(1'b1, "R11");
    wr(3'd5, 32'h1);                 // E+11 no clear bit
    rd(3'd5, 32'h7, "R10");          // E+12
    wr(3'd5, 32'h0);                 // E+13 mask off
    rd(3'd5, 32'h2, "R9");           // E+14
    chk_irq(1'b0, "R9");
    wr(3'd4, 32'h0);                 // E+15 expiry then stop, count 3
    rd(3'd2, 32'd3, "R4");
    idle(2);
    rd(3'd2, 32'd3, "R13");
    wr(3'd0, 32'd10);
    wr(3'd4, 32'h3);                 // re-arm
    rd(3'd2, 32'd10, "R3");
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h8);
    rd(3'd5, 32'h0, "R10");

    // R8: 64-bit borrow, start 0x1_0000_0000
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h1);
    wr(3'd4, 32'h0001_0002);         // E
    rd(3'd3, 32'h1, "R8");           // E+1
    rd(3'd3, 32'h0, "R8");           // E+2 borrowed
    rd(3'd2, 32'hFFFF_FFFE, "R8");   // E+3
    rd(3'd5, 32'h0, "R8");           // no expiry at low half 0
    rd(3'd4, 32'h0001_0002, "R2");
    wr(3'd4, 32'h0);

    // R12: shadow capture
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'h0001_0003);         // E
    rd(3'd6, 32'hFFFF_FFFF, "R12");  // E+1 captures high FFFFFFFF
    rd(3'd6, 32'hFFFF_FFFE, "R12");  // E+2
    wr(3'd4, 32'h0);                 // E+3
    wr(3'd1, 32'h22);                // E+4
    wr(3'd4, 32'h0001_0002);         // E+5 count 0x22_FFFFFFFF
    rd(3'd3, 32'h22, "R12");         // E+6 live high
    rd(3'd7, 32'hFFFF_FFFF, "R12");  // E+7 captured high
    rd(3'd6, 32'hFFFF_FFFD, "R12");  // E+8 captures 0x22
    rd(3'd7, 32'h22, "R12");         // E+9
    wr(3'd4, 32'h0);

    idle(3);
    if (expq.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R13 pending reads actual=%0d expected=0", expq.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule